// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block takes an asynchronous, active-low power-down request and walks a set of generated clocks into and out of a quiet state. The request is first brought into the internal clock domain through two flops. Each output then stops LOW on its own falling edge, so no output ever produces a shortened high pulse. Once every output gate is closed, the VCO enable drops, and the oscillator enable drops one cycle after that.

On release, the order runs in reverse. The oscillator enable comes back first and the VCO enable follows one cycle later. The outputs stay held LOW for a configurable number of lock cycles, and only then do their gates reopen, each one while its own source is low.

Per-output enable bits hold individual outputs LOW through the same glitch-free gates. A global tristate flag drives every output-enable inactive, whatever else is set. The PLL and the crystal are outside the block. The generated clocks arrive as `src_clk`, sampled in the internal domain, and lock is modelled by a counter.

States: `ST_OSC_UP` (oscillator on, VCO off, entered from reset or from release), `ST_LOCK` (both on, counting `LOCK_CYCLES`), `ST_RUN` (gates follow the enable bits), `ST_DRAIN` (gates closing), `ST_PLL_DOWN` (VCO off, one cycle), `ST_SLEEP` (both off). The transitions are:

- `ST_OSC_UP` to `ST_LOCK` after one cycle.
- `ST_LOCK` to `ST_RUN` when the counter expires.
- `ST_RUN` to `ST_DRAIN` on a synchronized request.
- `ST_DRAIN` to `ST_PLL_DOWN` once all gates are closed.
- `ST_PLL_DOWN` to `ST_SLEEP` after one cycle.
- `ST_SLEEP` to `ST_OSC_UP` when the synchronized request is released.

Top module: `clkstop_seq`

## Requirements
- R1: `pd_n` passes through a two-flop synchronizer. For the first two clock edges after it changes, the block's outputs behave as before the change.
- R2: A gate changes state only at an edge where its source clock is sampled low. An output therefore never has a high pulse cut short, and never starts a pulse in the middle of a source high phase.
- R3: After a request, every `clk_out` bit is LOW within 20 cycles, and both `osc_en` and `vco_en` are 0.
- R4: `vco_en` falls only after every gate is closed. `osc_en` falls only after `vco_en` is already 0, and `vco_en` is never 1 while `osc_en` is 0.
- R5: On release, `osc_en` is 1 with `vco_en` still 0 at the third edge after `pd_n` rises. `vco_en` rises one cycle later. All outputs then stay LOW for at least `LOCK_CYCLES` cycles after `vco_en` rises.
- R6: In the running state, `clk_out[i]` equals `src_clk[i] & out_en[i]`. An enable bit of 0 holds its output LOW.
- R7: `clk_oe` is a registered copy of the inverted tristate flag: all zeros one cycle after `tristate` is 1, and all ones otherwise.
- R8: While reset is held, `osc_en`=1, `vco_en`=0, `clk_out`=0 and `clk_oe`=0. Out of reset the block passes through the lock wait before any output runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| tristate | input | 1 | Forces all output-enables inactive |
| out_en | input | N_OUT | Per-output enable, 1 = run |
| src_clk | input | N_OUT | Generated clocks before gating |
| clk_out | output | N_OUT | Gated clock outputs |
| clk_oe | output | N_OUT | Output-enables, 1 = driven |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |

## Verification
The assertions check on every cycle that a gate moves only while its source is low, that the VCO is never on without the oscillator, and that the VCO drops only with all gates closed. They also check that gates stay shut on the cycle after the VCO returns and that every output is LOW whenever the oscillator is off. Only the bench scenarios can show the timing figures: the two-edge synchronizer delay, the exact cycle at which the oscillator returns before the VCO, and the full length of the lock wait. The same holds for the bound on stopping time, the effect of the enable mask and the registered tristate override.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    typedef enum logic [2:0] {
        ST_OSC_UP   = 3'd0,
        ST_LOCK     = 3'd1,
        ST_RUN      = 3'd2,
        ST_DRAIN    = 3'd3,
        ST_PLL_DOWN = 3'd4,
        ST_SLEEP    = 3'd5
    } seq_state_t;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic want_open,
    output logic open_q
);
    // Gate state may only move while the source is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    open_q <= 1'b0;
        else if (!src) open_q <= want_open;
    end
endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
    import clkstop_pkg::*;
#(
    parameter int LOCK_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic all_closed,
    output logic run_ok,
    output logic osc_en,
    output logic vco_en
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYCLES - 1);

    seq_state_t state_q, state_d;
    logic [CW-1:0] lock_cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OSC_UP:   state_d = ST_LOCK;
            ST_LOCK:     if (lock_cnt_q == LOCK_LAST) state_d = ST_RUN;
            ST_RUN:      if (stop_req) state_d = ST_DRAIN;
            ST_DRAIN:    if (all_closed) state_d = ST_PLL_DOWN;
            ST_PLL_DOWN: state_d = ST_SLEEP;
            ST_SLEEP:    if (!stop_req) state_d = ST_OSC_UP;
            default:     state_d = ST_OSC_UP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_OSC_UP;
            lock_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOCK) lock_cnt_q <= lock_cnt_q + 1'b1;
            else                    lock_cnt_q <= '0;
        end
    end

    always_comb begin
        run_ok = 1'b0;
        osc_en = 1'b0;
        vco_en = 1'b0;
        unique case (state_q)
            ST_OSC_UP:   begin osc_en = 1'b1; end
            ST_LOCK:     begin osc_en = 1'b1; vco_en = 1'b1; end
            ST_RUN:      begin osc_en = 1'b1; vco_en = 1'b1; run_ok = 1'b1; end
            ST_DRAIN:    begin osc_en = 1'b1; vco_en = 1'b1; end
            ST_PLL_DOWN: begin osc_en = 1'b1; end
            ST_SLEEP:    begin end
            default:     begin end
        endcase
    end
endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq #(
    parameter int N_OUT       = 6,
    parameter int LOCK_CYCLES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             tristate,
    input  logic [N_OUT-1:0] out_en,
    input  logic [N_OUT-1:0] src_clk,
    output logic [N_OUT-1:0] clk_out,
    output logic [N_OUT-1:0] clk_oe,
    output logic             osc_en,
    output logic             vco_en
);
    logic             pd_n_sync;
    logic             run_ok;
    logic [N_OUT-1:0] gate_q;
    logic [N_OUT-1:0] oe_q;

    clkstop_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pd_n),
        .q_sync  (pd_n_sync)
    );

    clkstop_fsm #(.LOCK_CYCLES(LOCK_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stop_req   (~pd_n_sync),
        .all_closed (~|gate_q),
        .run_ok     (run_ok),
        .osc_en     (osc_en),
        .vco_en     (vco_en)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_gate
        clkstop_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .src       (src_clk[i]),
            .want_open (run_ok & out_en[i]),
            .open_q    (gate_q[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= '0;
        else        oe_q <= {N_OUT{~tristate}};
    end

    assign clk_out = src_clk & gate_q;
    assign clk_oe  = oe_q;
endmodule

// File: rtl/clkstop_seq_chk.sv
module clkstop_seq_chk #(
    parameter int N_OUT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_OUT-1:0] src_clk,
    input logic [N_OUT-1:0] gate_q,
    input logic [N_OUT-1:0] clk_out,
    input logic             osc_en,
    input logic             vco_en
);
    a_r2_gate_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_q ^ $past(gate_q)) & $past(src_clk)) == '0)
        else $error("gate changed while source high");

    a_r4_vco_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        vco_en |-> osc_en)
        else $error("vco on without oscillator");

    a_r4_vco_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en) |-> $past(gate_q) == '0)
        else $error("vco dropped with a gate open");

    a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_en) |=> gate_q == '0)
        else $error("gate opened right after vco start");

    a_r3_sleep_low: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> clk_out == '0)
        else $error("output active with oscillator off");
endmodule

bind clkstop_seq clkstop_seq_chk #(.N_OUT(N_OUT)) u_chk (.*);

// File: tb/clkstop_seq_tb.sv
module clkstop_seq_tb;
    localparam int N  = 6;
    localparam int LK = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pd_n = 1'b1;
    logic         tristate = 1'b0;
    logic [N-1:0] out_en = '1;
    logic [N-1:0] src = '0;
    logic [N-1:0] clk_out, clk_oe;
    logic         osc_en, vco_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        string        tag;
        bit           live;
        logic [N-1:0] val;
        logic [N-1:0] oe;
        logic         osc;
        logic         vco;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    clkstop_seq #(.N_OUT(N), .LOCK_CYCLES(LK)) u_dut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .tristate(tristate),
        .out_en(out_en), .src_clk(src), .clk_out(clk_out), .clk_oe(clk_oe),
        .osc_en(osc_en), .vco_en(vco_en)
    );

    // Source clock model: runs only while both oscillator and VCO are on.
    int div_cnt [N];
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (osc_en && vco_en) begin
                if (div_cnt[i] >= i) begin
                    div_cnt[i] = 0;
                    src[i] <= ~src[i];
                end else div_cnt[i] = div_cnt[i] + 1;
            end else begin
                div_cnt[i] = 0;
                src[i] <= 1'b0;
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(string tag, bit live, logic [N-1:0] val,
                        logic [N-1:0] oe, logic osc, logic vco);
        item_t it;
        it.tag = tag; it.live = live; it.val = val;
        it.oe = oe; it.osc = osc; it.vco = vco;
        q.push_back(it);
    endtask

    // Monitor: pops expected items and checks continuous rules.
    logic [N-1:0] p_out = '0, p_src = '0;
    logic         p_vco = 1'b0, p_osc = 1'b1;
    int           since_vco = 1000;
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            logic [N-1:0] e;
            it = q.pop_front();
            e = it.live ? (src & it.val) : it.val;
            chk({it.tag, " out"}, 64'(clk_out), 64'(e));
            chk({it.tag, " oe"},  64'(clk_oe),  64'(it.oe));
            chk({it.tag, " osc"}, 64'(osc_en),  64'(it.osc));
            chk({it.tag, " vco"}, 64'(vco_en),  64'(it.vco));
        end
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (p_out[i] && !clk_out[i])
                    chk("R2 fall with source", 64'(src[i]), 64'(0));
                if (!p_out[i] && clk_out[i])
                    chk("R2 rise with source", 64'(p_src[i]), 64'(0));
            end
            if (p_vco && !vco_en) begin
                chk("R4 gates shut before vco off", 64'(p_out), 64'(0));
                chk("R4 osc still on at vco off", 64'(osc_en), 64'(1));
            end
            if (p_osc && !osc_en)
                chk("R4 vco off before osc", 64'(p_vco), 64'(0));
            if (!p_vco && vco_en) since_vco = 0;
            else if (since_vco < 1000) since_vco++;
            if (since_vco <= LK)
                chk("R5 outputs low in lock", 64'(clk_out), 64'(0));
        end
        p_out = clk_out; p_src = src; p_vco = vco_en; p_osc = osc_en;
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        wait_n(3);
        push("R8 reset", 0, '0, '0, 1, 0);
        wait_n(2);
        rst_n = 1'b1;
        wait_n(LK + 30);
        for (int k = 0; k < 6; k++) begin
            push("R6 all enabled", 1, '1, '1, 1, 1);
            wait_n(1);
        end
        out_en = 6'b101101;
        wait_n(20);
        for (int k = 0; k < 8; k++) begin
            push("R6 masked", 1, 6'b101101, '1, 1, 1);
            wait_n(1);
        end
        out_en = '1;
        wait_n(20);
        tristate = 1'b1;
        wait_n(2);
        push("R7 tristate on", 1, '1, '0, 1, 1);
        wait_n(1);
        tristate = 1'b0;
        wait_n(2);
        push("R7 tristate off", 1, '1, '1, 1, 1);
        wait_n(3);
        // Power-down request
        pd_n = 1'b0;
        push("R1 edge1", 1, '1, '1, 1, 1);
        wait_n(1);
        push("R1 edge2", 1, '1, '1, 1, 1);
        wait_n(1);
        push("R1 edge3", 1, '1, '1, 1, 1);
        wait_n(25);
        push("R3 stopped", 0, '0, '1, 0, 0);
        wait_n(10);
        push("R3 still stopped", 0, '0, '1, 0, 0);
        wait_n(3);
        // Release
        pd_n = 1'b1;
        wait_n(2);
        push("R5 osc first", 0, '0, '1, 1, 0);
        wait_n(1);
        push("R5 vco next", 0, '0, '1, 1, 1);
        wait_n(LK + 30);
        for (int k = 0; k < 6; k++) begin
            push("R5 running again", 1, '1, '1, 1, 1);
            wait_n(1);
        end
        wait_n(3);
        finish_run();
    end
endmodule